// File: doc/BRIEF.md
# Byte-Packing Transfer Data Buffer

This block sits between a 16-bit host data register and a byte-serial transfer engine. A single shift register, `BUF_BYTES` bytes wide, holds bytes waiting to go out and bytes that have come in. The host loads outgoing data with 16-bit or 8-bit writes. Each write shifts the register left, so the oldest byte always sits highest. The engine takes outgoing bytes one at a time from the top of the pending set. In the other direction, the engine deposits incoming bytes from byte lane 0 upward. The host drains them two at a time with 16-bit reads.

An order input chooses how the two bytes of a host word map onto buffer lanes, for both writes and reads. Separate transmit and receive byte counts are kept. Alongside the data, the block keeps five status flags:
- single-byte read
- transmit ready
- receive ready
- transmit underflow
- receive overrun

The engine raises the last two; host data accesses clear them.

Only one operation is performed per clock. When several strobes arrive together, a fixed priority picks one: host write, then host read, then engine pop, then engine push.

Top module: `pack_buf`

## Requirements
- R1: After reset, both byte counts are 0, all five flags are 0 and `rd_data` is 0.
- R2: A 16-bit write accepted while `tx_count` is at most `BUF_BYTES-2` adds 2 to `tx_count`. With `big_order`=1 the engine later receives `wr_data[15:8]` before `wr_data[7:0]`; with `big_order`=0 it receives `wr_data[7:0]` first.
- R3: A write of either width arriving while `tx_count` exceeds `BUF_BYTES-2` is ignored. The count and the pending bytes are left unchanged.
- R4: An 8-bit write (`wr_byte`=1) appends `wr_data[7:0]` and adds 1 to `tx_count`. Bytes leave in the order they were written, across writes of both widths.
- R5: `tx_byte` shows the oldest pending byte. A pop removes it and lowers `tx_count` by 1. A pop at `tx_count`=0 has no effect.
- R6: Pushed bytes fill lanes from lane 0 upward and `rx_count` rises by 1, up to `BUF_BYTES`. A push while `rx_count`=`BUF_BYTES` is ignored.
- R7: During a read, `rd_data` shows lanes 0 and 1. Lane 0 goes to bits 15:8 when `big_order`=1 and to bits 7:0 when it is 0. A read with `rx_count` of 2 or more lowers it by 2. When `rx_count` exceeds 2, the read also shifts the buffer down by two lanes.
- R8: A read with `rx_count`=1 sets the single-byte flag and zeroes `rx_count`. The flag stays set until `ack_single`.
- R9: A read with `rx_count`=0 changes neither count nor buffer, so `rd_data` is unchanged.
- R10: An accepted push sets receive-ready. A read that brings `rx_count` to 0 clears it.
- R11: An accepted write that leaves `tx_count` above `BUF_BYTES-2` clears transmit-ready. A pop that leaves `tx_count` at or below `BUF_BYTES-2` sets it.
- R12: `udf_set` raises the underflow flag and an accepted write clears it. `ovr_set` raises the overrun flag and any read clears it.
- R13: Only one operation is performed per cycle, chosen in the order write, read, pop, push. The others are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| big_order | input | 1 | Byte order of the host word |
| wr_en | input | 1 | Host data write strobe |
| wr_byte | input | 1 | 1 = 8-bit write, 0 = 16-bit write |
| wr_data | input | 16 | Host write data |
| rd_en | input | 1 | Host data read strobe |
| rd_data | output | 16 | Host read data (lanes 1:0, ordered) |
| tx_pop | input | 1 | Engine takes the next transmit byte |
| tx_byte | output | 8 | Oldest pending transmit byte |
| rx_push | input | 1 | Engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| udf_set | input | 1 | Engine reports transmit underflow |
| ovr_set | input | 1 | Engine reports receive overrun |
| ack_single | input | 1 | Clears the single-byte flag |
| tx_count | output | CNT_W | Pending transmit bytes |
| rx_count | output | CNT_W | Held receive bytes |
| single_flag | output | 1 | A read found one byte |
| tx_ready | output | 1 | Room for another host word |
| rx_ready | output | 1 | Received data available |
| udf_flag | output | 1 | Transmit underflow |
| ovr_flag | output | 1 | Receive overrun |

## Verification
The bench builds the block with its default `BUF_BYTES`=4. With that size, two 16-bit writes reach the rejection threshold, and four pushes reach a full receive side. This puts write rejection, the full-push drop and the shifting read within a handful of cycles. The odd-count case is reached by pushing three bytes, which leads to a single-byte read. Both byte orders are run for both the write and the read direction.

// File: rtl/pack_buf_pkg.sv
// Shared types for the byte-packing buffer.
// Assumes: one operation is chosen per clock by pack_buf_sel.
package pack_buf_pkg;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_WR16,
        OP_WR8,
        OP_READ,
        OP_POP,
        OP_PUSH
    } buf_op_e;

endpackage

// File: rtl/pack_buf_sel.sv
// Operation selector: turns the five strobes into one operation per cycle.
// Assumes strobes are single-cycle and synchronous to clk.
module pack_buf_sel
    import pack_buf_pkg::*;
(
    input  logic    wr_en,
    input  logic    wr_byte,
    input  logic    rd_en,
    input  logic    tx_pop,
    input  logic    rx_push,
    output buf_op_e op
);

    // Fixed priority: host write, host read, engine pop, engine push.
    always_comb begin
        if (wr_en)        op = wr_byte ? OP_WR8 : OP_WR16;
        else if (rd_en)   op = OP_READ;
        else if (tx_pop)  op = OP_POP;
        else if (rx_push) op = OP_PUSH;
        else              op = OP_IDLE;
    end

endmodule

// File: rtl/pack_buf_store.sv
// Shift-register storage with transmit and receive byte counts.
// Writes shift in from lane 0 upward; pops take the byte at index count-1;
// pushes fill at index rx count; reads consume lanes 1:0.
// Assumes BUF_BYTES >= 3 and one op per cycle.
module pack_buf_store
    import pack_buf_pkg::*;
#(
    parameter int BUF_BYTES = 4,
    parameter int CNT_W     = $clog2(BUF_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  buf_op_e          op,
    input  logic             big_order,
    input  logic [15:0]      wr_data,
    input  logic [7:0]       rx_byte,
    output logic [CNT_W-1:0] tx_cnt,
    output logic [CNT_W-1:0] rx_cnt,
    output logic [7:0]       tx_byte,
    output logic [15:0]      rd_data,
    output logic             wr_ok,
    output logic             wr_fills,
    output logic             pop_room,
    output logic             rd_any,
    output logic             rd_single,
    output logic             rd_empties,
    output logic             push_ok
);

    localparam int BUF_W = BUF_BYTES * 8;
    localparam int IDX_W = $clog2(BUF_BYTES);
    localparam int LIMIT = BUF_BYTES - 2;

    logic [BUF_W-1:0] buf_q, buf_d, push_buf;
    logic [CNT_W-1:0] tx_q, tx_d, rx_q, rx_d;
    logic [7:0]       lane [BUF_BYTES];
    logic [15:0]      word_in;

    // Byte lanes of the register and the push-updated image, one per lane.
    for (genvar i = 0; i < BUF_BYTES; i++) begin : g_lane
        assign lane[i] = buf_q[i*8 +: 8];
        assign push_buf[i*8 +: 8] = (rx_q == CNT_W'(i)) ? rx_byte : buf_q[i*8 +: 8];
    end

    // Host word mapped onto lanes 1:0 according to the byte order input.
    assign word_in = big_order ? wr_data : {wr_data[7:0], wr_data[15:8]};

    // Read view of lanes 1:0 in host order.
    assign rd_data = big_order ? {lane[0], lane[1]} : {lane[1], lane[0]};

    // Oldest pending transmit byte.
    assign tx_byte = (tx_q != '0) ? lane[IDX_W'(tx_q - CNT_W'(1))] : 8'h00;

    // Next-state computation for buffer and counts.
    always_comb begin
        buf_d = buf_q;
        tx_d  = tx_q;
        rx_d  = rx_q;
        unique case (op)
            OP_WR16: if (tx_q <= CNT_W'(LIMIT)) begin
                buf_d = {buf_q[BUF_W-17:0], word_in};
                tx_d  = tx_q + CNT_W'(2);
            end
            OP_WR8: if (tx_q <= CNT_W'(LIMIT)) begin
                buf_d = {buf_q[BUF_W-9:0], wr_data[7:0]};
                tx_d  = tx_q + CNT_W'(1);
            end
            OP_READ: begin
                if (rx_q > CNT_W'(2)) buf_d = buf_q >> 16;
                if (rx_q == CNT_W'(1))      rx_d = '0;
                else if (rx_q != '0)        rx_d = rx_q - CNT_W'(2);
            end
            OP_POP:  if (tx_q != '0) tx_d = tx_q - CNT_W'(1);
            OP_PUSH: if (rx_q < CNT_W'(BUF_BYTES)) begin
                buf_d = push_buf;
                rx_d  = rx_q + CNT_W'(1);
            end
            default: ;
        endcase
    end

    // Event strobes consumed by the flag logic.
    assign wr_ok      = (op == OP_WR16 || op == OP_WR8) && (tx_q <= CNT_W'(LIMIT));
    assign wr_fills   = wr_ok && (tx_d > CNT_W'(LIMIT));
    assign pop_room   = (op == OP_POP) && (tx_q != '0) && (tx_d <= CNT_W'(LIMIT));
    assign rd_any     = (op == OP_READ);
    assign rd_single  = rd_any && (rx_q == CNT_W'(1));
    assign rd_empties = rd_any && (rx_q != '0) && (rx_d == '0);
    assign push_ok    = (op == OP_PUSH) && (rx_q < CNT_W'(BUF_BYTES));

    // State registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
            tx_q  <= '0;
            rx_q  <= '0;
        end else begin
            buf_q <= buf_d;
            tx_q  <= tx_d;
            rx_q  <= rx_d;
        end
    end

    assign tx_cnt = tx_q;
    assign rx_cnt = rx_q;

    // R2: transmit count never exceeds the buffer size.
    p_tx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_q <= CNT_W'(BUF_BYTES));

    // R3: a write beyond the threshold leaves the transmit count alone.
    p_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == OP_WR16 || op == OP_WR8) && tx_q > CNT_W'(LIMIT)) |=> $stable(tx_q));

    // R5: a pop on a non-empty transmit side lowers the count by one.
    p_pop_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_POP && tx_q != '0) |=> (tx_q == $past(tx_q) - CNT_W'(1)));

    // R6: receive count never exceeds the buffer size.
    p_rx_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_q <= CNT_W'(BUF_BYTES));

    // R9: a read of an empty receive side leaves the buffer untouched.
    p_rd_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_READ && rx_q == '0) |=> ($stable(buf_q) && rx_q == '0));

endmodule

// File: rtl/pack_buf_flags.sv
// Status flags of the buffer, driven by event strobes from pack_buf_store.
// Assumes the strobes describe the operation performed this cycle.
module pack_buf_flags #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] rx_cnt,
    input  logic             wr_ok,
    input  logic             wr_fills,
    input  logic             pop_room,
    input  logic             rd_any,
    input  logic             rd_single,
    input  logic             rd_empties,
    input  logic             push_ok,
    input  logic             udf_set,
    input  logic             ovr_set,
    input  logic             ack_single,
    output logic             single_flag,
    output logic             tx_ready,
    output logic             rx_ready,
    output logic             udf_flag,
    output logic             ovr_flag
);

    // Flag registers: clear-on-event and set-on-event, synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            single_flag <= 1'b0;
            tx_ready    <= 1'b0;
            rx_ready    <= 1'b0;
            udf_flag    <= 1'b0;
            ovr_flag    <= 1'b0;
        end else begin
            if (rd_single)       single_flag <= 1'b1;
            else if (ack_single) single_flag <= 1'b0;

            if (wr_fills)        tx_ready <= 1'b0;
            else if (pop_room)   tx_ready <= 1'b1;

            if (push_ok)         rx_ready <= 1'b1;
            else if (rd_empties) rx_ready <= 1'b0;

            if (wr_ok)           udf_flag <= 1'b0;
            else if (udf_set)    udf_flag <= 1'b1;

            if (rd_any)          ovr_flag <= 1'b0;
            else if (ovr_set)    ovr_flag <= 1'b1;
        end
    end

    // R8: a single-byte read raises the flag on the next cycle.
    p_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_single |=> single_flag);

    // R10: receive-ready is never shown over an empty receive side.
    p_rxrdy_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt == '0) |-> !rx_ready);

    // R12: an accepted write leaves underflow cleared.
    p_udf_clr_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> !udf_flag);

endmodule

// File: rtl/pack_buf.sv
// Top of the byte-packing buffer: selector, storage and flags.
// Assumes the host word is 16 bits and the engine side is byte wide.
module pack_buf
    import pack_buf_pkg::*;
#(
    parameter int BUF_BYTES = 4,
    parameter int CNT_W     = $clog2(BUF_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             big_order,
    input  logic             wr_en,
    input  logic             wr_byte,
    input  logic [15:0]      wr_data,
    input  logic             rd_en,
    output logic [15:0]      rd_data,
    input  logic             tx_pop,
    output logic [7:0]       tx_byte,
    input  logic             rx_push,
    input  logic [7:0]       rx_byte,
    input  logic             udf_set,
    input  logic             ovr_set,
    input  logic             ack_single,
    output logic [CNT_W-1:0] tx_count,
    output logic [CNT_W-1:0] rx_count,
    output logic             single_flag,
    output logic             tx_ready,
    output logic             rx_ready,
    output logic             udf_flag,
    output logic             ovr_flag
);

    buf_op_e op;
    logic wr_ok, wr_fills, pop_room, rd_any, rd_single, rd_empties, push_ok;

    pack_buf_sel u_sel (
        .wr_en   (wr_en),
        .wr_byte (wr_byte),
        .rd_en   (rd_en),
        .tx_pop  (tx_pop),
        .rx_push (rx_push),
        .op      (op)
    );

    pack_buf_store #(.BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (op),
        .big_order  (big_order),
        .wr_data    (wr_data),
        .rx_byte    (rx_byte),
        .tx_cnt     (tx_count),
        .rx_cnt     (rx_count),
        .tx_byte    (tx_byte),
        .rd_data    (rd_data),
        .wr_ok      (wr_ok),
        .wr_fills   (wr_fills),
        .pop_room   (pop_room),
        .rd_any     (rd_any),
        .rd_single  (rd_single),
        .rd_empties (rd_empties),
        .push_ok    (push_ok)
    );

    pack_buf_flags #(.CNT_W(CNT_W)) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_cnt      (rx_count),
        .wr_ok       (wr_ok),
        .wr_fills    (wr_fills),
        .pop_room    (pop_room),
        .rd_any      (rd_any),
        .rd_single   (rd_single),
        .rd_empties  (rd_empties),
        .push_ok     (push_ok),
        .udf_set     (udf_set),
        .ovr_set     (ovr_set),
        .ack_single  (ack_single),
        .single_flag (single_flag),
        .tx_ready    (tx_ready),
        .rx_ready    (rx_ready),
        .udf_flag    (udf_flag),
        .ovr_flag    (ovr_flag)
    );

endmodule

// File: tb/pack_buf_test.sv
// Directed bench for pack_buf: one task per scenario, each checking itself.
module pack_buf_test;

    localparam int CNT_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic big_order = 1'b1;
    logic wr_en = 1'b0, wr_byte = 1'b0, rd_en = 1'b0, tx_pop = 1'b0, rx_push = 1'b0;
    logic [15:0] wr_data = '0;
    logic [7:0]  rx_byte = '0;
    logic udf_set = 1'b0, ovr_set = 1'b0, ack_single = 1'b0;
    logic [15:0] rd_data;
    logic [7:0]  tx_byte;
    logic [CNT_W-1:0] tx_count, rx_count;
    logic single_flag, tx_ready, rx_ready, udf_flag, ovr_flag;

    int total = 0;
    int failed = 0;

    always #2 clk = ~clk;

    pack_buf uut (
        .clk(clk), .rst_n(rst_n), .big_order(big_order),
        .wr_en(wr_en), .wr_byte(wr_byte), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data),
        .tx_pop(tx_pop), .tx_byte(tx_byte),
        .rx_push(rx_push), .rx_byte(rx_byte),
        .udf_set(udf_set), .ovr_set(ovr_set), .ack_single(ack_single),
        .tx_count(tx_count), .rx_count(rx_count),
        .single_flag(single_flag), .tx_ready(tx_ready), .rx_ready(rx_ready),
        .udf_flag(udf_flag), .ovr_flag(ovr_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_inputs();
        wr_en = 0; wr_byte = 0; rd_en = 0; tx_pop = 0; rx_push = 0;
        udf_set = 0; ovr_set = 0; ack_single = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); clear_inputs(); rst_n = 0;
        @(posedge clk); #1 rst_n = 1;
    endtask

    task automatic wr16(input logic [15:0] d);
        @(negedge clk); wr_en = 1; wr_byte = 0; wr_data = d;
        @(posedge clk); #1 clear_inputs();
    endtask

    task automatic wr8(input logic [7:0] d);
        @(negedge clk); wr_en = 1; wr_byte = 1; wr_data = {8'h00, d};
        @(posedge clk); #1 clear_inputs();
    endtask

    task automatic pop(output logic [7:0] b);
        @(negedge clk); tx_pop = 1; b = tx_byte;
        @(posedge clk); #1 clear_inputs();
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk); rx_push = 1; rx_byte = b;
        @(posedge clk); #1 clear_inputs();
    endtask

    task automatic rd16(output logic [15:0] d);
        @(negedge clk); rd_en = 1; d = rd_data;
        @(posedge clk); #1 clear_inputs();
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 tx_count", tx_count, 0);
        chk("R1 rx_count", rx_count, 0);
        chk("R1 flags", {single_flag, tx_ready, rx_ready, udf_flag, ovr_flag}, 0);
        chk("R1 rd_data", rd_data, 0);
    endtask

    task automatic t_write_orders();
        logic [7:0] b;
        do_reset(); big_order = 1;
        wr16(16'hABCD);
        chk("R2 count after write", tx_count, 2);
        pop(b); chk("R2 big first byte", b, 8'hAB);
        pop(b); chk("R2 big second byte", b, 8'hCD);
        chk("R5 count after pops", tx_count, 0);
        pop(b); chk("R5 pop at zero", tx_count, 0);
        big_order = 0;
        wr16(16'h1234);
        pop(b); chk("R2 little first byte", b, 8'h34);
        pop(b); chk("R2 little second byte", b, 8'h12);
        big_order = 1;
    endtask

    task automatic t_reject();
        logic [7:0] b;
        do_reset(); big_order = 1;
        wr16(16'hA1B2);
        wr16(16'hC3D4);
        chk("R11 tx_ready cleared at full", tx_ready, 0);
        wr16(16'hEEFF);
        chk("R3 16-bit rejected", tx_count, 4);
        wr8(8'h99);
        chk("R3 8-bit rejected", tx_count, 4);
        pop(b); chk("R3 byte 0 kept", b, 8'hA1);
        chk("R11 not ready above threshold", tx_ready, 0);
        pop(b); chk("R3 byte 1 kept", b, 8'hB2);
        chk("R11 ready at threshold", tx_ready, 1);
        wr16(16'hE5F6);
        chk("R11 cleared again", tx_ready, 0);
        pop(b); chk("R3 byte 2 kept", b, 8'hC3);
        pop(b); chk("R3 byte 3 kept", b, 8'hD4);
    endtask

    task automatic t_byte_writes();
        logic [7:0] b;
        do_reset(); big_order = 1;
        wr8(8'h11);
        chk("R4 count +1", tx_count, 1);
        wr8(8'h22);
        wr16(16'h3344);
        chk("R4 mixed count", tx_count, 4);
        pop(b); chk("R4 order 0", b, 8'h11);
        pop(b); chk("R4 order 1", b, 8'h22);
        pop(b); chk("R4 order 2", b, 8'h33);
        pop(b); chk("R4 order 3", b, 8'h44);
    endtask

    task automatic t_rx_even();
        logic [15:0] d;
        do_reset(); big_order = 1;
        push(8'hA1); chk("R10 rx_ready on push", rx_ready, 1);
        push(8'hA2); push(8'hA3); push(8'hA4);
        push(8'hA5);
        chk("R6 full push ignored", rx_count, 4);
        rd16(d); chk("R7 big read lanes", d, 16'hA1A2);
        chk("R7 count -2", rx_count, 2);
        chk("R10 still ready", rx_ready, 1);
        rd16(d); chk("R6 no overwrite by full push", d, 16'hA3A4);
        chk("R7 count zero", rx_count, 0);
        chk("R10 cleared on empty", rx_ready, 0);
        chk("R8 no single on even", single_flag, 0);
    endtask

    task automatic t_rx_odd();
        logic [15:0] d;
        logic [15:0] pre;
        do_reset(); big_order = 0;
        push(8'hB1); push(8'hB2); push(8'hB3);
        rd16(d); chk("R7 little read lanes", d, 16'hB2B1);
        chk("R7 count 3->1", rx_count, 1);
        rd16(d); chk("R7 shifted low byte", d[7:0], 8'hB3);
        chk("R8 single flag", single_flag, 1);
        chk("R8 count zero", rx_count, 0);
        @(negedge clk); ack_single = 1; @(posedge clk); #1 clear_inputs();
        chk("R8 ack clears", single_flag, 0);
        pre = rd_data;
        rd16(d);
        chk("R9 empty read stale", rd_data, pre);
        chk("R9 count stays 0", rx_count, 0);
        chk("R9 no single flag", single_flag, 0);
        big_order = 1;
    endtask

    task automatic t_flags();
        logic [15:0] d;
        do_reset();
        @(negedge clk); udf_set = 1; ovr_set = 1; @(posedge clk); #1 clear_inputs();
        chk("R12 udf set", udf_flag, 1);
        chk("R12 ovr set", ovr_flag, 1);
        wr16(16'h0102);
        chk("R12 write clears udf", udf_flag, 0);
        chk("R12 ovr kept by write", ovr_flag, 1);
        rd16(d);
        chk("R12 read clears ovr", ovr_flag, 0);
    endtask

    task automatic t_priority();
        do_reset();
        @(negedge clk); wr_en = 1; wr_byte = 0; wr_data = 16'h5566; rx_push = 1; rx_byte = 8'h77;
        @(posedge clk); #1 clear_inputs();
        chk("R13 write wins tx", tx_count, 2);
        chk("R13 push dropped", rx_count, 0);
        @(negedge clk); tx_pop = 1; rx_push = 1; rx_byte = 8'h77;
        @(posedge clk); #1 clear_inputs();
        chk("R13 pop wins", tx_count, 1);
        chk("R13 push dropped again", rx_count, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; failed++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        t_reset();
        t_write_orders();
        t_reject();
        t_byte_writes();
        t_rx_even();
        t_rx_odd();
        t_flags();
        t_priority();
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

endmodule